// File: doc/BRIEF.md
# PCI Host Bridge CPU-Side Address Decoder

This block sits between a CPU bus and the PCI side of a host bridge. Each CPU request carries an address, a byte size, a read/write flag and write data. The block sorts the request into one of several targets: configuration space, I/O space, the configuration index or data register inside I/O space, PCI memory, the interrupt acknowledge port, or nothing. It also produces the address the downstream side should use. Malformed or unmapped requests raise an error flag and carry no target. One cycle after the request strobe, the block presents the result as a registered response.

A mode input selects how the 8 MB CPU I/O window folds onto the 64 KB PCI I/O space. In contiguous mode, the low 16 address bits are kept. In sparse mode, each 4 KB page carries 32 usable bytes. Two smaller paths share the block. A bus-master path maps addresses from PCI devices onto PCI memory or system memory. An interrupt path either spreads the four pins of every slot across two lines by slot parity, or merges all pins onto one line.

The request path is a two-state machine. In IDLE, no response is shown. A strobe moves it to RESP, and RESP shows the result for exactly one cycle. From RESP, a new strobe keeps it in RESP (back-to-back), and the absence of a strobe returns it to IDLE. Reset enters IDLE.

Top module: `pci_host_decoder`

## Requirements
- R1: A request strobe at a clock edge produces `rsp_valid` high for the following cycle, with `rsp_write` and `rsp_wdata` equal to the request's values. A cycle without a strobe produces no response in the next cycle.
- R2: Addresses 0x8080_0000 to 0x80BF_FFFF decode as configuration (target code 1). The device index is the position of the lowest set bit among address bits 21..11, counted from bit 11, or 11 if none of those bits is set. The output address is the index shifted left by 11, ORed with address bits 10..0.
- R3: Addresses 0x8000_0000 to 0x807F_FFFF with the mode input at 0 decode as I/O (code 2) with output address = address bits 15..0. Unaligned accesses of size 2 or 4 raise no error.
- R4: With the mode input at 1, the I/O output address is address bits 22..12 placed at bits 15..5, with address bits 4..0 kept.
- R5: A translated I/O address in 0xCF8..0xCFB decodes as configuration index (code 5), and one in 0xCFC..0xCFF decodes as configuration data (code 6). In both cases the output address is the byte offset (translated address bits 1..0).
- R6: Each request uses the mode input value present at its own strobe edge. Back-to-back requests with different mode values decode independently.
- R7: Addresses 0xC000_0000 to 0xFEFF_FFFF decode as PCI memory (code 3) with output address = address − 0xC000_0000.
- R8: Address 0xBFFF_FFF0 with size 1 decodes as interrupt acknowledge (code 4). A read returns the vector input, sampled at the strobe edge, in `rsp_rdata`. A write leaves `rsp_rdata` at 0 and raises no error. Any other size at that address is an error.
- R9: A size other than 1, 2 or 4 sets `rsp_err`, with target code 0 and output address 0, regardless of address.
- R10: An address outside every window sets `rsp_err`, with target code 0 and output address 0. `rsp_rdata` is 0 on every response except an interrupt acknowledge read.
- R11: A bus-master address strobed by `bm_valid` yields `bm_rsp_valid` one cycle later. Addresses below 0x3F00_0000 select PCI memory (`bm_sel`=1) at the same address. Addresses with bit 31 set select system memory (`bm_sel`=2) at the address minus 0x8000_0000. All other addresses select nothing (`bm_sel`=0) with output address 0.
- R12: With `irq_split`=1, pin n (bit s*4+n of `pci_int`) of slot s drives `irq_out[(n+s) mod 2]`, registered one cycle.
- R13: With `irq_split`=0, `irq_out[0]` is the OR of all pins and `irq_out[1]` is 0, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request strobe |
| req_addr | input | 32 | CPU address |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Little-endian write data |
| io_sparse | input | 1 | I/O map mode: 0 contiguous, 1 sparse |
| irq_vector | input | VEC_W | Vector from the interrupt controller |
| rsp_valid | output | 1 | Response valid |
| rsp_target | output | 3 | Target code (0 none, 1 config, 2 I/O, 3 memory, 4 int-ack, 5 cfg index, 6 cfg data) |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_err | output | 1 | Decode error |
| rsp_write | output | 1 | Registered write flag |
| rsp_wdata | output | DW | Registered write data |
| rsp_rdata | output | DW | Interrupt acknowledge read data |
| bm_valid | input | 1 | Bus-master address strobe |
| bm_addr | input | 32 | Bus-master address |
| bm_rsp_valid | output | 1 | Bus-master result valid |
| bm_sel | output | 2 | 0 none, 1 PCI memory, 2 system memory |
| bm_out_addr | output | 32 | Translated bus-master address |
| irq_split | input | 1 | 1 = two-line parity routing, 0 = merged |
| pci_int | input | NUM_SLOTS*4 | Interrupt pins, slot-major |
| irq_out | output | 2 | Routed interrupt lines |

## Verification
A wrong state register shows up at the ports within one cycle. Either a response is missing after a strobe, or an extra `rsp_valid` appears in a cycle after no strobe. A wrong device-index priority or sparse bit placement shows up as a wrong `rsp_addr` on the very response to that request. Mode or vector values captured at the wrong edge show up only in back-to-back traffic, where the second response carries the first request's setting. That is why the stimulus includes strobes in adjacent cycles with differing mode.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_CFG  = 3'd1,
        TGT_IO   = 3'd2,
        TGT_MEM  = 3'd3,
        TGT_IACK = 3'd4,
        TGT_CIDX = 3'd5,
        TGT_CDAT = 3'd6
    } tgt_e;

    typedef enum logic [1:0] {
        BM_NONE = 2'd0,
        BM_PCI  = 2'd1,
        BM_SYS  = 2'd2
    } bm_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } req_state_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [31:0] addr;
        logic        err;
    } dec_t;

    localparam logic [31:0] MEM_BASE  = 32'hC000_0000;
    localparam logic [31:0] MEM_END   = 32'hFF00_0000;
    localparam logic [31:0] IACK_ADDR = 32'hBFFF_FFF0;
    localparam logic [31:0] BM_PCI_END = 32'h3F00_0000;
    localparam logic [9:0]  CFG_TAG   = 10'h202;
    localparam logic [8:0]  IO_TAG    = 9'h100;
    localparam int          SEL_LO    = 11;
    localparam int          SEL_BITS  = 11;
endpackage

// File: rtl/pcihb_cpu_decode.sv
module pcihb_cpu_decode
    import pcihb_pkg::*;
(
    input  logic [31:0] addr,
    input  logic [2:0]  size,
    input  logic        sparse,
    output dec_t        dec
);
    localparam int IDX_W = $clog2(SEL_BITS + 1);

    logic [IDX_W-1:0] dev_idx;
    logic [15:0]      io_addr;
    logic             size_ok, cfg_hit, io_hit, mem_hit, iack_hit;

    always_comb begin
        dev_idx = IDX_W'(SEL_BITS);
        for (int i = SEL_BITS - 1; i >= 0; i--) begin
            if (addr[SEL_LO + i]) dev_idx = IDX_W'(i);
        end
    end

    always_comb begin
        io_addr  = sparse ? {addr[22:12], addr[4:0]} : addr[15:0];
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        cfg_hit  = (addr[31:22] == CFG_TAG);
        io_hit   = (addr[31:23] == IO_TAG);
        mem_hit  = (addr >= MEM_BASE) && (addr < MEM_END);
        iack_hit = (addr == IACK_ADDR);
    end

    always_comb begin
        dec = '{tgt: TGT_NONE, addr: '0, err: 1'b1};
        if (size_ok) begin
            if (cfg_hit) begin
                dec = '{tgt: TGT_CFG, err: 1'b0,
                        addr: {17'd0, dev_idx, addr[10:0]}};
            end else if (io_hit) begin
                if (io_addr[15:2] == 14'h33E)
                    dec = '{tgt: TGT_CIDX, addr: {30'd0, io_addr[1:0]}, err: 1'b0};
                else if (io_addr[15:2] == 14'h33F)
                    dec = '{tgt: TGT_CDAT, addr: {30'd0, io_addr[1:0]}, err: 1'b0};
                else
                    dec = '{tgt: TGT_IO, addr: {16'd0, io_addr}, err: 1'b0};
            end else if (mem_hit) begin
                dec = '{tgt: TGT_MEM, addr: addr - MEM_BASE, err: 1'b0};
            end else if (iack_hit && size == 3'd1) begin
                dec = '{tgt: TGT_IACK, addr: '0, err: 1'b0};
            end
        end
    end
endmodule

// File: rtl/pcihb_bm_map.sv
module pcihb_bm_map
    import pcihb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bm_valid,
    input  logic [31:0] bm_addr,
    output logic        bm_rsp_valid,
    output logic [1:0]  bm_sel,
    output logic [31:0] bm_out_addr
);
    bm_e         sel_d;
    logic [31:0] addr_d;

    always_comb begin
        sel_d  = BM_NONE;
        addr_d = '0;
        if (bm_addr[31]) begin
            sel_d  = BM_SYS;
            addr_d = {1'b0, bm_addr[30:0]};
        end else if (bm_addr < BM_PCI_END) begin
            sel_d  = BM_PCI;
            addr_d = bm_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bm_rsp_valid <= 1'b0;
            bm_sel       <= BM_NONE;
            bm_out_addr  <= '0;
        end else begin
            bm_rsp_valid <= bm_valid;
            if (bm_valid) begin
                bm_sel      <= sel_d;
                bm_out_addr <= addr_d;
            end
        end
    end

    // R11
    bm_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid && bm_addr[31] |=> bm_rsp_valid && bm_sel == BM_SYS
                                    && bm_out_addr[31] == 1'b0);
endmodule

// File: rtl/pcihb_irq_route.sv
module pcihb_irq_route #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   split,
    input  logic [NUM_SLOTS*4-1:0] pins,
    output logic [1:0]             irq_out
);
    localparam int NPINS = NUM_SLOTS * 4;

    logic [NPINS-1:0] odd_mask;
    logic             ev, od;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar n = 0; n < 4; n++) begin : g_pin
            assign odd_mask[s*4+n] = ((s + n) % 2) == 1;
        end
    end

    always_comb begin
        od = |(pins & odd_mask);
        ev = |(pins & ~odd_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 2'b00;
        else        irq_out <= split ? {od, ev} : {1'b0, ev | od};
    end

    // R13
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !split |=> irq_out[1] == 1'b0 && irq_out[0] == $past(|pins));
endmodule

// File: rtl/pci_host_decoder.sv
module pci_host_decoder
    import pcihb_pkg::*;
#(
    parameter int DW        = 32,
    parameter int VEC_W     = 8,
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [31:0]            req_addr,
    input  logic [2:0]             req_size,
    input  logic                   req_write,
    input  logic [DW-1:0]          req_wdata,
    input  logic                   io_sparse,
    input  logic [VEC_W-1:0]       irq_vector,
    output logic                   rsp_valid,
    output logic [2:0]             rsp_target,
    output logic [31:0]            rsp_addr,
    output logic                   rsp_err,
    output logic                   rsp_write,
    output logic [DW-1:0]          rsp_wdata,
    output logic [DW-1:0]          rsp_rdata,
    input  logic                   bm_valid,
    input  logic [31:0]            bm_addr,
    output logic                   bm_rsp_valid,
    output logic [1:0]             bm_sel,
    output logic [31:0]            bm_out_addr,
    input  logic                   irq_split,
    input  logic [NUM_SLOTS*4-1:0] pci_int,
    output logic [1:0]             irq_out
);
    req_state_e state_q, state_d;
    dec_t       dec;
    dec_t       dec_q;
    logic       wr_q;
    logic [DW-1:0] wdata_q, rdata_q;

    pcihb_cpu_decode u_dec (
        .addr   (req_addr),
        .size   (req_size),
        .sparse (io_sparse),
        .dec    (dec)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '{tgt: TGT_NONE, addr: '0, err: 1'b0};
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (req_valid) begin
            dec_q   <= dec;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            rdata_q <= (dec.tgt == TGT_IACK && !req_write)
                       ? DW'(irq_vector) : '0;
        end
    end

    always_comb begin
        rsp_valid  = (state_q == ST_RESP);
        rsp_target = dec_q.tgt;
        rsp_addr   = dec_q.addr;
        rsp_err    = dec_q.err;
        rsp_write  = wr_q;
        rsp_wdata  = wdata_q;
        rsp_rdata  = rdata_q;
    end

    pcihb_bm_map u_bm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bm_valid     (bm_valid),
        .bm_addr      (bm_addr),
        .bm_rsp_valid (bm_rsp_valid),
        .bm_sel       (bm_sel),
        .bm_out_addr  (bm_out_addr)
    );

    pcihb_irq_route #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .split   (irq_split),
        .pins    (pci_int),
        .irq_out (irq_out)
    );

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && rsp_wdata == $past(req_wdata));

    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4)
        |=> rsp_err && rsp_target == TGT_NONE);

    // R8
    iack_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_target == TGT_IACK && rsp_write |-> rsp_rdata == '0);
endmodule

// File: tb/tb_pci_host_decoder.sv
`timescale 1ns/1ps
module tb_pci_host_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        io_sparse = 1'b0;
    logic [7:0]  irq_vector = 8'h5A;
    logic        rsp_valid, rsp_err, rsp_write;
    logic [2:0]  rsp_target;
    logic [31:0] rsp_addr, rsp_wdata, rsp_rdata;
    logic        bm_valid = 1'b0;
    logic [31:0] bm_addr = '0;
    logic        bm_rsp_valid;
    logic [1:0]  bm_sel;
    logic [31:0] bm_out_addr;
    logic        irq_split = 1'b1;
    logic [15:0] pci_int = '0;
    logic [1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  tgt;
        logic [31:0] addr;
        logic        err;
        logic [31:0] rdata;
        logic        wr;
        logic [31:0] wd;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    pci_host_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .io_sparse(io_sparse), .irq_vector(irq_vector), .rsp_valid(rsp_valid),
        .rsp_target(rsp_target), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
        .rsp_write(rsp_write), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
        .bm_valid(bm_valid), .bm_addr(bm_addr), .bm_rsp_valid(bm_rsp_valid),
        .bm_sel(bm_sel), .bm_out_addr(bm_out_addr), .irq_split(irq_split),
        .pci_int(pci_int), .irq_out(irq_out)
    );

    function automatic exp_t model(logic [31:0] a, int sz, bit wr, bit sp);
        exp_t e;
        logic [31:0] io;
        int idx;
        bit found;
        e.tgt = 3'd0; e.addr = '0; e.err = 1'b1; e.rdata = '0; e.wr = wr;
        e.wd = '0; e.tag = "";
        if (!(sz == 1 || sz == 2 || sz == 4)) return e;
        if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
            idx = 11; found = 0;
            for (int i = 0; i < 11; i++)
                if (!found && a[11+i]) begin idx = i; found = 1; end
            e.tgt = 3'd1; e.err = 0; e.addr = (idx << 11) | (a & 32'h7FF);
        end else if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
            io = sp ? (((a & 32'h007F_F000) >> 7) | (a & 32'h1F)) : (a & 32'hFFFF);
            e.err = 0;
            if (io >= 32'hCF8 && io < 32'hCFC)      begin e.tgt = 3'd5; e.addr = io & 3; end
            else if (io >= 32'hCFC && io < 32'hD00) begin e.tgt = 3'd6; e.addr = io & 3; end
            else                                     begin e.tgt = 3'd2; e.addr = io; end
        end else if (a >= 32'hC000_0000 && a < 32'hFF00_0000) begin
            e.tgt = 3'd3; e.err = 0; e.addr = a - 32'hC000_0000;
        end else if (a == 32'hBFFF_FFF0 && sz == 1) begin
            e.tgt = 3'd4; e.err = 0; e.rdata = wr ? 32'd0 : {24'd0, irq_vector};
        end
        return e;
    endfunction

    // driver: call at a falling edge, returns at the next falling edge
    task automatic send(logic [31:0] a, int sz, bit wr, bit sp, string tag);
        exp_t e;
        req_valid = 1; req_addr = a; req_size = 3'(sz); req_write = wr;
        io_sparse = sp; req_wdata = a ^ 32'hA5A5_0000;
        e = model(a, sz, wr, sp);
        e.wd = req_wdata; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(0, "R1", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_target == e.tgt, e.tag, "target", 32'(rsp_target), 32'(e.tgt));
                check(rsp_addr == e.addr, e.tag, "addr", rsp_addr, e.addr);
                check(rsp_err == e.err, e.tag, "err", 32'(rsp_err), 32'(e.err));
                check(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
                check(rsp_write == e.wr && rsp_wdata == e.wd, "R1", "write passthrough",
                      rsp_wdata, e.wd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid == 0 && bm_rsp_valid == 0 && irq_out == 0, "R1", "reset state",
              {29'd0, rsp_valid, irq_out}, 32'd0);

        // R2 configuration window
        send(32'h8080_0810, 4, 0, 0, "R2");
        send(32'h8080_4024, 4, 1, 0, "R2");
        send(32'h8080_0004, 1, 0, 0, "R2");
        send(32'h80A0_87FF, 2, 0, 1, "R2");
        // R3 contiguous I/O, unaligned sizes
        send(32'h8012_3456, 1, 1, 0, "R3");
        send(32'h8000_0101, 2, 0, 0, "R3");
        send(32'h807F_FFFE, 4, 0, 0, "R3");
        // R4 sparse I/O
        send(32'h8040_501F, 1, 0, 1, "R4");
        send(32'h807F_FFE3, 2, 1, 1, "R4");
        // R5 configuration index / data registers
        send(32'h8000_0CF8, 4, 1, 0, "R5");
        send(32'h8001_0CFE, 2, 0, 0, "R5");
        send(32'h8006_7018, 4, 1, 1, "R5");
        send(32'h8000_0D00, 1, 0, 0, "R5");
        // R6 back-to-back with differing mode, same address
        send(32'h8040_501F, 1, 0, 1, "R6");
        send(32'h8040_501F, 1, 0, 0, "R6");
        // R7 PCI memory
        send(32'hC000_1234, 4, 0, 0, "R7");
        send(32'hFEFF_FFFC, 4, 1, 0, "R7");
        // R8 interrupt acknowledge
        send(32'hBFFF_FFF0, 1, 0, 0, "R8");
        irq_vector = 8'hC3;
        send(32'hBFFF_FFF0, 1, 0, 0, "R8");
        send(32'hBFFF_FFF0, 1, 1, 0, "R8");
        send(32'hBFFF_FFF0, 2, 0, 0, "R8");
        // R9 illegal sizes
        send(32'h8000_0010, 3, 0, 0, "R9");
        send(32'hC000_0000, 0, 1, 0, "R9");
        send(32'h8080_0800, 7, 0, 0, "R9");
        // R10 unmapped
        send(32'h1000_0000, 4, 0, 0, "R10");
        send(32'h80C0_0000, 4, 0, 0, "R10");
        send(32'hFF00_0000, 1, 0, 0, "R10");
        send(32'hBFFF_FFF1, 1, 0, 0, "R10");
        repeat (2) @(negedge clk);
        check(q.size() == 0, "R1", "missing responses", 32'(q.size()), 32'd0);

        // R11 bus-master mapping
        bm_valid = 1; bm_addr = 32'h0012_3400;
        @(negedge clk);
        check(bm_rsp_valid && bm_sel == 2'd1 && bm_out_addr == 32'h0012_3400, "R11",
              "pci mem", bm_out_addr, 32'h0012_3400);
        bm_addr = 32'h9000_0040;
        @(negedge clk);
        check(bm_rsp_valid && bm_sel == 2'd2 && bm_out_addr == 32'h1000_0040, "R11",
              "sys mem", bm_out_addr, 32'h1000_0040);
        bm_addr = 32'h3F00_0000;
        @(negedge clk);
        check(bm_rsp_valid && bm_sel == 2'd0 && bm_out_addr == 32'd0, "R11",
              "unmapped", {30'd0, bm_sel}, 32'd0);
        bm_valid = 0;
        @(negedge clk);
        check(bm_rsp_valid == 0, "R11", "valid drop", 32'(bm_rsp_valid), 32'd0);

        // R12 split routing
        irq_split = 1; pci_int = 16'h0001;          // slot0 pin0 -> line0
        @(negedge clk);
        check(irq_out == 2'b01, "R12", "slot0 pin0", 32'(irq_out), 32'd1);
        pci_int = 16'h0010;                         // slot1 pin0 -> line1
        @(negedge clk);
        check(irq_out == 2'b10, "R12", "slot1 pin0", 32'(irq_out), 32'd2);
        pci_int = 16'h0800;                         // slot2 pin3 -> line1
        @(negedge clk);
        check(irq_out == 2'b10, "R12", "slot2 pin3", 32'(irq_out), 32'd2);
        pci_int = 16'h2004;                         // slot3 pin1 -> 0, slot0 pin2 -> 0
        @(negedge clk);
        check(irq_out == 2'b01, "R12", "even pair", 32'(irq_out), 32'd1);
        // R13 merged
        irq_split = 0; pci_int = 16'h0010;
        @(negedge clk);
        check(irq_out == 2'b01, "R13", "merged odd pin", 32'(irq_out), 32'd1);
        pci_int = 16'h0000;
        @(negedge clk);
        check(irq_out == 2'b00, "R13", "merged idle", 32'(irq_out), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule